// File: doc/BRIEF.md
# Sequencer Program Memory Loader

This block lets a host fill and inspect the 512-word, 32-bit program memory of an embedded microsequencer through a narrow byte-wide register bus. The host first sets a load-enable bit in a control register. It then places a starting word address in two address registers: one holds the low eight bits, and the other holds the ninth bit in its bit 0. After that the host streams bytes through a single data window register.

The block collects the bytes least significant first. When the fourth byte arrives, it writes the complete 32-bit word into the memory in that same cycle. The word address then steps forward by one, and it wraps from the top of the memory back to zero. Reading the data window returns the bytes of the addressed word in the same lane order, and the fourth read also advances the address. A second control bit drives a hold-in-reset output to the sequencer.

The memory port assumes a read that is combinational: `ram_rdata` shows the word at `ram_addr` in the same cycle.

Top module: `seq_iram_loader`

## Requirements
- R1: After synchronous reset, every register reads 0, `ram_addr` is 0, `seq_rst_o` and `load_en_o` are low, and `ram_we` stays low while there is no bus activity.
- R2: The control register is `reg_sel`=0. Bit 0 is the load enable and bit 1 is the sequencer reset. `load_en_o` and `seq_rst_o` follow those bits from the cycle after the write. A read returns the two bits in positions 1:0, with zeros above them.
- R3: With load enabled, four writes to the data window (`reg_sel`=1) form one word, with the first byte in bits 7:0 and the fourth byte in bits 31:24. `ram_we` is high only in the cycle of the fourth write, and `ram_wdata` then carries the whole word.
- R4: The word address (`ram_addr`) is unchanged by the first three data-window accesses of a word. It increments by one in the cycle after the fourth access.
- R5: The word address is formed from the low address register (`reg_sel`=2), which supplies bits 7:0, and bit 0 of the high address register (`reg_sel`=3), which supplies bit 8. The other bits written to the high register are discarded, and reading the high register returns only bit 8 of the address.
- R6: A write to either address register restarts byte collection at lane 0. Bytes of a partial word written before it never reach the memory.
- R7: While load is disabled, writes to the data window do not assert `ram_we` and do not change the address or the byte lane.
- R8: With load enabled, a read of the data window returns the byte of `ram_rdata` selected by the current lane, and the fourth read advances the address. With load disabled, the window reads 0 and the read advances nothing.
- R9: The address wraps from 511 to 0 when the last word is written or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the data window) |
| reg_sel | input | 2 | Register select: 0 control, 1 data window, 2 address low, 3 address high |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ram_we | output | 1 | Program memory write enable |
| ram_addr | output | 9 | Program memory word address |
| ram_wdata | output | 32 | Program memory write word |
| ram_rdata | input | 32 | Program memory read word at `ram_addr` |
| seq_rst_o | output | 1 | Hold-in-reset to the sequencer |
| load_en_o | output | 1 | Load enable, to the sequencer and the memory arbitration |

## Verification
A byte lane counter that has drifted shows up at the fourth data write of the next word. That write either lands a cycle early or late, or it arrives with its bytes rotated in `ram_wdata`. A wrong word address appears on `ram_addr` right away, and the bench compares that port against its model on every clock. Staging bytes that were corrupted or discarded show up only when `ram_we` fires, or later, when the word is read back byte by byte through the window.

// File: rtl/sqld_pkg.sv
`timescale 1ns/1ps
package sqld_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_DATA    = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } reg_sel_e;

    // bit 1: sequencer reset, bit 0: load enable
    typedef struct packed {
        logic seq_rst;
        logic load;
    } ctrl_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_req_t;

    function automatic logic hit_wr(input bus_req_t r, input reg_sel_e s);
        return r.wr && (r.sel == s);
    endfunction

    // a read counts only when no write shares the cycle
    function automatic logic hit_rd(input bus_req_t r, input reg_sel_e s);
        return r.rd && !r.wr && (r.sel == s);
    endfunction

endpackage

// File: rtl/sqld_ctrl.sv
`timescale 1ns/1ps
module sqld_ctrl
    import sqld_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] din,
    output ctrl_t      q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= ctrl_t'(din);
    end
endmodule

// File: rtl/sqld_addr.sv
`timescale 1ns/1ps
module sqld_addr #(
    parameter int ADDR_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [7:0]          lo_din,
    input  logic [ADDR_W-9:0]   hi_din,
    input  logic                step,
    output logic [ADDR_W-1:0]   addr
);
    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (ld_lo)
            addr[7:0] <= lo_din;
        else if (ld_hi)
            addr[ADDR_W-1:8] <= hi_din;
        else if (step)
            addr <= addr + 1'b1;   // natural wrap at the top word
    end
endmodule

// File: rtl/sqld_lane.sv
`timescale 1ns/1ps
module sqld_lane #(
    parameter int LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         advance,
    input  logic                         capture,
    input  logic [7:0]                   din,
    output logic [$clog2(LANES)-1:0]     lane,
    output logic                         last,
    output logic [8*(LANES-1)-1:0]       staged
);
    localparam int LANE_W = $clog2(LANES);

    assign last = (lane == LANE_W'(LANES - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            lane <= '0;
        else if (advance)
            lane <= last ? '0 : lane + 1'b1;
    end

    for (genvar g = 0; g < LANES - 1; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                staged[8*g +: 8] <= '0;
            else if (capture && lane == LANE_W'(g))
                staged[8*g +: 8] <= din;
        end
    end
endmodule

// File: rtl/seq_iram_loader.sv
`timescale 1ns/1ps
module seq_iram_loader
    import sqld_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [1:0]            reg_sel,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    output logic                  ram_we,
    output logic [ADDR_W-1:0]     ram_addr,
    output logic [8*LANES-1:0]    ram_wdata,
    input  logic [8*LANES-1:0]    ram_rdata,
    output logic                  seq_rst_o,
    output logic                  load_en_o
);
    localparam int LANE_W = $clog2(LANES);
    localparam int HI_W   = ADDR_W - 8;

    bus_req_t            req;
    ctrl_t               ctrl;
    logic                wr_data, rd_data, lane_last;
    logic [LANE_W-1:0]   lane;
    logic [8*(LANES-1)-1:0] staged;

    assign req = '{wr: reg_wr, rd: reg_rd, sel: reg_sel_e'(reg_sel)};

    assign wr_data = ctrl.load && hit_wr(req, SEL_DATA);
    assign rd_data = ctrl.load && hit_rd(req, SEL_DATA);

    sqld_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (hit_wr(req, SEL_CTRL)),
        .din   (reg_wdata[1:0]),
        .q     (ctrl)
    );

    sqld_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .ld_lo  (hit_wr(req, SEL_ADDR_LO)),
        .ld_hi  (hit_wr(req, SEL_ADDR_HI)),
        .lo_din (reg_wdata),
        .hi_din (reg_wdata[HI_W-1:0]),
        .step   ((wr_data || rd_data) && lane_last),
        .addr   (ram_addr)
    );

    sqld_lane #(.LANES(LANES)) u_lane (
        .clk     (clk),
        .rst     (rst),
        .clear   (hit_wr(req, SEL_ADDR_LO) || hit_wr(req, SEL_ADDR_HI)),
        .advance (wr_data || rd_data),
        .capture (wr_data),
        .din     (reg_wdata),
        .lane    (lane),
        .last    (lane_last),
        .staged  (staged)
    );

    assign ram_we    = wr_data && lane_last;
    assign ram_wdata = {reg_wdata, staged};
    assign seq_rst_o = ctrl.seq_rst;
    assign load_en_o = ctrl.load;

    always_comb begin
        unique case (req.sel)
            SEL_CTRL:    reg_rdata = 8'(ctrl);
            SEL_DATA:    reg_rdata = ctrl.load ? ram_rdata[8*int'(lane) +: 8] : 8'h00;
            SEL_ADDR_LO: reg_rdata = ram_addr[7:0];
            SEL_ADDR_HI: reg_rdata = 8'(ram_addr >> 8);
            default:     reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sqld_checker.sv
`timescale 1ns/1ps
module sqld_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_sel,
    input logic [7:0]        reg_wdata,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        wr_top,
    input logic              seq_rst_o,
    input logic              load_en_o
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ram_addr == '0 && !seq_rst_o && !load_en_o));

    a_r2_ctrl_bits: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd0) |=>
            (load_en_o == $past(reg_wdata[0]) && seq_rst_o == $past(reg_wdata[1])));

    a_r3_we_source: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (reg_wr && reg_sel == 2'd1 && load_en_o && wr_top == reg_wdata));

    // R9: the increment is taken modulo the address width
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> ram_addr == ADDR_W'($past(ram_addr) + 1'b1));

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !(ram_we || (reg_wr && reg_sel[1]) || (reg_rd && reg_sel == 2'd1 && load_en_o))
            |=> $stable(ram_addr));

    a_r5_addr_split: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd3) |=> ram_addr[ADDR_W-1:8] == $past(reg_wdata[ADDR_W-9:0]));

    a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd1 && !load_en_o) |-> !ram_we);

    a_r7_addr_kept: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd1 && !load_en_o) |=> $stable(ram_addr));
endmodule

bind seq_iram_loader sqld_checker #(.ADDR_W(ADDR_W)) u_sqld_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .wr_top    (ram_wdata[8*LANES-1 -: 8]),
    .seq_rst_o (seq_rst_o),
    .load_en_o (load_en_o)
);

// File: tb/seq_iram_loader_bench.sv
`timescale 1ns/1ps
module seq_iram_loader_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        ram_we;
    logic [8:0]  ram_addr;
    logic [31:0] ram_wdata, ram_rdata;
    logic        seq_rst_o, load_en_o;

    always #2.5 clk = ~clk;

    seq_iram_loader u_seq_iram_loader (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .seq_rst_o(seq_rst_o), .load_en_o(load_en_o)
    );

    // environment memory, combinational read
    logic [31:0] tb_ram [512];
    assign ram_rdata = tb_ram[ram_addr];
    always @(posedge clk) if (ram_we) tb_ram[ram_addr] <= ram_wdata;

    // reference model
    logic [8:0]  m_addr = '0;
    int          m_lane = 0;
    logic [1:0]  m_ctrl = '0;
    logic [7:0]  m_stg [3];
    logic [31:0] m_mem [512];
    int n_chk = 0, n_bad = 0;
    bit done = 0, live = 0;

    initial begin
        for (int i = 0; i < 512; i++) begin tb_ram[i] = '0; m_mem[i] = '0; end
        for (int i = 0; i < 3; i++) m_stg[i] = '0;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [1:0] s);
        case (s)
            2'd0: return {6'b0, m_ctrl};
            2'd1: return m_ctrl[0] ? m_mem[m_addr][m_lane*8 +: 8] : 8'h00;
            2'd2: return m_addr[7:0];
            default: return {7'b0, m_addr[8]};
        endcase
    endfunction

    // every clock: registered outputs against the model
    always @(negedge clk) begin
        if (live) begin
            check("R4", "ram_addr", {23'b0, ram_addr}, {23'b0, m_addr});
            check("R2", "seq_rst_o", {31'b0, seq_rst_o}, {31'b0, m_ctrl[1]});
            check("R2", "load_en_o", {31'b0, load_en_o}, {31'b0, m_ctrl[0]});
        end
    end

    task automatic op(input bit wr, input bit rd, input logic [1:0] s,
                      input logic [7:0] d, input string req);
        bit          we_exp;
        logic [31:0] wd_exp;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_sel = s; reg_wdata = d;
        we_exp = wr && s == 2'd1 && m_ctrl[0] && m_lane == 3;
        wd_exp = {d, m_stg[2], m_stg[1], m_stg[0]};
        #1;
        check(req, "ram_we", {31'b0, ram_we}, {31'b0, we_exp});
        if (we_exp) check(req, "ram_wdata", ram_wdata, wd_exp);
        if (rd && !wr) check(req, "reg_rdata", {24'b0, reg_rdata}, {24'b0, exp_rdata(s)});
        @(posedge clk);
        #1;
        if (wr) begin
            case (s)
                2'd0: m_ctrl = d[1:0];
                2'd1: if (m_ctrl[0]) begin
                    if (m_lane == 3) begin
                        m_mem[m_addr] = wd_exp; m_addr = m_addr + 1'b1; m_lane = 0;
                    end else begin
                        m_stg[m_lane] = d; m_lane++;
                    end
                end
                2'd2: begin m_addr[7:0] = d; m_lane = 0; end
                default: begin m_addr[8] = d[0]; m_lane = 0; end
            endcase
        end else if (rd && s == 2'd1 && m_ctrl[0]) begin
            if (m_lane == 3) begin m_addr = m_addr + 1'b1; m_lane = 0; end
            else m_lane++;
        end
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d, input string req);
        op(1'b1, 1'b0, s, d, req);
    endtask

    task automatic rd(input logic [1:0] s, input string req);
        op(1'b0, 1'b1, s, 8'h00, req);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        live = 1;

        // R1: reset state
        for (int s = 0; s < 4; s++) rd(2'(s), "R1");

        // R7: data writes without load enable
        for (int i = 0; i < 4; i++) wr(2'd1, 8'(8'h90 + i), "R7");
        rd(2'd2, "R7");

        // R2: control bits
        wr(2'd0, 8'h03, "R2");
        rd(2'd0, "R2");
        wr(2'd0, 8'hFD, "R2");
        rd(2'd0, "R2");

        // R5: address split
        wr(2'd3, 8'hFF, "R5");
        rd(2'd3, "R5");
        wr(2'd2, 8'h10, "R5");
        rd(2'd2, "R5");

        // R3 / R4: one word, address held until the fourth byte
        wr(2'd1, 8'h11, "R3"); rd(2'd2, "R4");
        wr(2'd1, 8'h22, "R3"); rd(2'd2, "R4");
        wr(2'd1, 8'h33, "R3"); rd(2'd2, "R4");
        wr(2'd1, 8'h44, "R3"); rd(2'd2, "R4");

        // R6: partial word dropped by an address write
        wr(2'd2, 8'h10, "R6");
        wr(2'd1, 8'hAA, "R6");
        wr(2'd1, 8'hBB, "R6");
        wr(2'd2, 8'h10, "R6");
        for (int i = 1; i <= 4; i++) wr(2'd1, 8'(i), "R6");

        // R8: read back through the window
        wr(2'd2, 8'h10, "R8");
        for (int i = 0; i < 4; i++) rd(2'd1, "R8");
        rd(2'd2, "R8");

        // R9: wrap on write, then wrap on read
        wr(2'd3, 8'h01, "R9");
        wr(2'd2, 8'hFF, "R9");
        for (int i = 0; i < 4; i++) wr(2'd1, 8'(8'hE0 + i), "R9");
        rd(2'd2, "R9");
        rd(2'd3, "R9");
        wr(2'd3, 8'h01, "R9");
        wr(2'd2, 8'hFF, "R9");
        for (int i = 0; i < 4; i++) rd(2'd1, "R9");
        rd(2'd3, "R9");

        // R8: window reads with load disabled
        wr(2'd0, 8'h00, "R8");
        rd(2'd1, "R8");
        rd(2'd1, "R8");
        rd(2'd2, "R8");

        // R3 / R8: a block of words, then read back
        wr(2'd0, 8'h01, "R3");
        wr(2'd3, 8'h00, "R3");
        wr(2'd2, 8'h20, "R3");
        for (int w = 0; w < 16; w++)
            for (int b = 0; b < 4; b++)
                wr(2'd1, 8'(w * 16 + b * 3 + 5), "R3");
        wr(2'd2, 8'h20, "R8");
        for (int i = 0; i < 64; i++) rd(2'd1, "R8");
        rd(2'd2, "R8");

        done = 1;
        summary();
        $finish;
    end
endmodule